// File: doc/BRIEF.md
# Event Block Readout Formatter

This block turns accepted trigger strobes into a stream of self-describing 32-bit readout words and groups the events into blocks. Every word with bit 31 set opens a new data type: a 4-bit tag sits in bits 30:27 and 27 payload bits below it. A word with bit 31 clear continues the type opened last. Each event holds an event header carrying the running trigger number and a two-word timestamp taken from a free-running 48-bit time counter. A block is opened by a header word and closed by a trailer word that reports how many words the block holds. Filler words after the trailer round the block length up to a multiple of 2 or 4.

When a trigger arrives, its timestamp is pushed into a small pending queue. A sequencer drains that queue and writes the words through a valid/ready path into an internal output buffer. A reader takes words out one at a time with a read strobe. A read of an empty buffer returns a no-data word. The busy output tells the trigger source to hold off while the output buffer is close to full.

Top module: `evblk_fmt`

## Requirements
- R1: A read strobe while the output buffer is empty returns the no-data word 0xF000_0000 (tag 14, zero payload) on `rd_data` after the next clock edge, and consumes nothing. Any other read returns the oldest buffered word after the next edge.
- R2: A block opens with a header word: bit 31 = 1, tag 0 in bits 30:27, slot identifier in bits 26:22, the block's event count in bits 21:11, block number in bits 10:0.
- R3: Each event opens with an event-header word: bit 31 = 1, tag 2, and the 27-bit trigger number in bits 26:0. The trigger number starts at 0 after reset and rises by one per accepted trigger, wrapping modulo 2^27.
- R4: Each event header is followed by two time words. The first is a tag-3 defining word with time bits 47:24 in bits 23:0 (bits 26:24 zero). The second is a continuation word (bits 31:24 zero) with time bits 23:0.
- R5: A block closes with a trailer word: bit 31 = 1, tag 1, slot identifier in bits 26:22, and in bits 21:0 the count of words from the header through the trailer inclusive, which is 2 + 3·N for N events.
- R6: Filler words 0xF800_0000 (tag 15) follow the trailer until the block's total length, fillers included, is a multiple of 2 when `pad4` = 0 or of 4 when `pad4` = 1. Fillers are not counted in the trailer.
- R7: The block number starts at 0 after reset and rises by one per block, modulo 2^11.
- R8: `busy` is low after reset. It is high in the cycle after the buffer holds at least BUSY_LVL words and low in the cycle after it holds fewer.
- R9: A trigger arriving while the pending-timestamp queue is full is dropped: it produces no event and does not advance the trigger number.
- R10: `evt_per_blk` and `pad4` are sampled when a block opens. An event count of 0 is treated as 1.
- R11: The time counter is held at zero while `glob_rst` is high and rises by one per clock afterwards. A trigger sampled k edges after the first edge with `glob_rst` low is stamped k.
- R12: Words leave in the order: header, then for each event its header and two time words, then trailer, then fillers. The first pending trigger opens a new block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the whole block |
| glob_rst | input | 1 | Global time reset; holds the time counter at zero |
| trig | input | 1 | Accepted-trigger strobe, one event per high cycle |
| slot_id | input | 5 | Slot identifier placed in header and trailer |
| evt_per_blk | input | 11 | Events per block (0 means 1) |
| pad4 | input | 1 | 0: pad blocks to 2 words, 1: pad to 4 words |
| rd_req | input | 1 | Read strobe for one word |
| rd_data | output | 32 | Word returned by the last read |
| busy | output | 1 | Output buffer is close to full |

## Verification
The bound checker tests on every cycle the cycle-exact relation between buffer level and `busy`, and the hold-at-zero and single-step behaviour of the time counter. It also checks the no-data word returned on empty reads, the zero upper byte of continuation words, and that a trigger arriving at a full pending queue does not grow it. Whole-block content can only be shown by the bench's scenarios. These cover the header and trailer fields, the trailer count, the filler count for each padding mode, the ordering of words, and the continuity of trigger and block numbers across blocks and across dropped triggers. The bench sweeps small event counts under both padding modes and works out every expected word arithmetically.

// File: rtl/evblk_pkg.sv
package evblk_pkg;
   localparam int WORD_W  = 32;
   localparam int TIME_W  = 48;
   localparam int SLOT_W  = 5;
   localparam int FLD11_W = 11;
   localparam int TNUM_W  = 27;
   localparam int WCNT_W  = 22;

   localparam logic [3:0] TAG_BLK_HEAD = 4'd0;
   localparam logic [3:0] TAG_BLK_TAIL = 4'd1;
   localparam logic [3:0] TAG_EVT_HEAD = 4'd2;
   localparam logic [3:0] TAG_TSTAMP   = 4'd3;
   localparam logic [3:0] TAG_NODATA   = 4'd14;
   localparam logic [3:0] TAG_PAD      = 4'd15;

   typedef enum logic [2:0] {
      ST_IDLE, ST_BHEAD, ST_EVHEAD, ST_TIME_HI, ST_TIME_LO, ST_BTAIL, ST_PAD
   } seq_st_t;

   function automatic logic [WORD_W-1:0] def_word(input logic [3:0] tag,
                                                  input logic [26:0] pl);
      return {1'b1, tag, pl};
   endfunction

   function automatic logic is_aligned(input logic [WCNT_W-1:0] n, input logic four);
      return four ? (n[1:0] == 2'b00) : (n[0] == 1'b0);
   endfunction
endpackage

// File: rtl/evblk_fifo.sv
module evblk_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 16,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             full,
   output logic             empty,
   output logic [CW-1:0]    level
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("evblk_fifo: DEPTH must be a power of two");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic             do_wr, do_rd;

   assign full  = (level == CW'(DEPTH));
   assign empty = (level == '0);
   assign do_wr = push && !full;
   assign do_rd = pop && !empty;
   assign head  = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_wr) wp <= wp + AW'(1);
         if (do_rd) rp <= rp + AW'(1);
         case ({do_wr, do_rd})
            2'b10:   level <= level + CW'(1);
            2'b01:   level <= level - CW'(1);
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= push_data;
   end
endmodule

// File: rtl/evblk_timer.sv
module evblk_timer #(
   parameter int TW = 48
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          glob_rst,
   output logic [TW-1:0] now
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        now <= '0;
      else if (glob_rst) now <= '0;
      else               now <= now + TW'(1);
   end
endmodule

// File: rtl/evblk_seq.sv
module evblk_seq
   import evblk_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SLOT_W-1:0]  slot_id,
   input  logic [FLD11_W-1:0] evt_cfg,
   input  logic               pad_cfg,
   input  logic               tq_empty,
   input  logic [TIME_W-1:0]  tq_time,
   output logic               tq_pop,
   output logic               ow_valid,
   output logic [WORD_W-1:0]  ow_data,
   input  logic               ow_ready
);
   seq_st_t            st;
   logic [TNUM_W-1:0]  trig_num;
   logic [FLD11_W-1:0] blk_num, evt_tgt, evt_done;
   logic [WCNT_W-1:0]  wcnt, wnext;
   logic               pad_lt, fire;

   assign wnext = wcnt + WCNT_W'(1);
   assign fire  = ow_valid && ow_ready;

   always_comb begin
      ow_valid = 1'b1;
      ow_data  = '0;
      case (st)
         ST_IDLE:    ow_valid = 1'b0;
         ST_BHEAD:   ow_data  = def_word(TAG_BLK_HEAD, {slot_id, evt_tgt, blk_num});
         ST_EVHEAD: begin
            ow_valid = !tq_empty;
            ow_data  = def_word(TAG_EVT_HEAD, trig_num);
         end
         ST_TIME_HI: ow_data  = def_word(TAG_TSTAMP, {3'b000, tq_time[47:24]});
         ST_TIME_LO: ow_data  = {8'h00, tq_time[23:0]};
         ST_BTAIL:   ow_data  = def_word(TAG_BLK_TAIL, {slot_id, wnext});
         ST_PAD:     ow_data  = def_word(TAG_PAD, 27'd0);
         default:    ow_valid = 1'b0;
      endcase
   end

   assign tq_pop = fire && (st == ST_TIME_LO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         trig_num <= '0;
         blk_num  <= '0;
         evt_tgt  <= FLD11_W'(1);
         evt_done <= '0;
         wcnt     <= '0;
         pad_lt   <= 1'b0;
      end else begin
         if (fire) wcnt <= wnext;
         case (st)
            ST_IDLE: if (!tq_empty) begin
               evt_tgt  <= (evt_cfg == '0) ? FLD11_W'(1) : evt_cfg;
               pad_lt   <= pad_cfg;
               evt_done <= '0;
               wcnt     <= '0;
               st       <= ST_BHEAD;
            end
            ST_BHEAD:  if (fire) st <= ST_EVHEAD;
            ST_EVHEAD: if (fire) begin
               trig_num <= trig_num + TNUM_W'(1);
               st       <= ST_TIME_HI;
            end
            ST_TIME_HI: if (fire) st <= ST_TIME_LO;
            ST_TIME_LO: if (fire) begin
               evt_done <= evt_done + FLD11_W'(1);
               st <= (FLD11_W'(evt_done + FLD11_W'(1)) == evt_tgt) ? ST_BTAIL : ST_EVHEAD;
            end
            ST_BTAIL: if (fire) begin
               blk_num <= blk_num + FLD11_W'(1);
               st      <= is_aligned(wnext, pad_lt) ? ST_IDLE : ST_PAD;
            end
            ST_PAD: if (fire && is_aligned(wnext, pad_lt)) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/evblk_fmt.sv
module evblk_fmt
   import evblk_pkg::*;
#(
   parameter int OBUF_DEPTH = 16,
   parameter int BUSY_LVL   = 12,
   parameter int TQ_DEPTH   = 4,
   parameter bit BUSY_REG   = 1'b1,
   localparam int OB_CW = $clog2(OBUF_DEPTH + 1),
   localparam int TQ_CW = $clog2(TQ_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               glob_rst,
   input  logic               trig,
   input  logic [SLOT_W-1:0]  slot_id,
   input  logic [FLD11_W-1:0] evt_per_blk,
   input  logic               pad4,
   input  logic               rd_req,
   output logic [WORD_W-1:0]  rd_data,
   output logic               busy
);
   if (BUSY_LVL < 1 || BUSY_LVL > OBUF_DEPTH) begin : g_bad_busy
      $error("evblk_fmt: BUSY_LVL must lie in 1..OBUF_DEPTH");
   end
   if (TQ_DEPTH < 2) begin : g_bad_tq
      $error("evblk_fmt: TQ_DEPTH must be at least 2");
   end

   localparam logic [WORD_W-1:0] NODATA_WORD = def_word(TAG_NODATA, 27'd0);

   logic [TIME_W-1:0] time_val, tq_time;
   logic              tq_full, tq_empty, tq_pop;
   logic [TQ_CW-1:0]  tq_lvl;
   logic              ow_valid, ow_ready;
   logic [WORD_W-1:0] ow_data, ob_head;
   logic              ob_full, ob_empty, ob_pop;
   logic [OB_CW-1:0]  ob_lvl;

   evblk_timer #(.TW(TIME_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .glob_rst(glob_rst), .now(time_val)
   );

   evblk_fifo #(.WIDTH(TIME_W), .DEPTH(TQ_DEPTH)) u_tq (
      .clk(clk), .rst_n(rst_n), .push(trig), .push_data(time_val),
      .pop(tq_pop), .head(tq_time), .full(tq_full), .empty(tq_empty), .level(tq_lvl)
   );

   evblk_seq u_seq (
      .clk(clk), .rst_n(rst_n), .slot_id(slot_id), .evt_cfg(evt_per_blk),
      .pad_cfg(pad4), .tq_empty(tq_empty), .tq_time(tq_time), .tq_pop(tq_pop),
      .ow_valid(ow_valid), .ow_data(ow_data), .ow_ready(ow_ready)
   );

   assign ow_ready = !ob_full;
   assign ob_pop   = rd_req && !ob_empty;

   evblk_fifo #(.WIDTH(WORD_W), .DEPTH(OBUF_DEPTH)) u_obuf (
      .clk(clk), .rst_n(rst_n), .push(ow_valid), .push_data(ow_data),
      .pop(ob_pop), .head(ob_head), .full(ob_full), .empty(ob_empty), .level(ob_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data <= NODATA_WORD;
      else if (rd_req) rd_data <= ob_empty ? NODATA_WORD : ob_head;
   end

   if (BUSY_REG) begin : g_busy_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy <= 1'b0;
         else        busy <= (ob_lvl >= OB_CW'(BUSY_LVL));
      end
   end else begin : g_busy_comb
      assign busy = (ob_lvl >= OB_CW'(BUSY_LVL));
   end
endmodule

// File: rtl/evblk_fmt_chk.sv
module evblk_fmt_chk #(
   parameter int OBUF_DEPTH = 16,
   parameter int BUSY_LVL   = 12,
   parameter int TQ_DEPTH   = 4,
   parameter bit BUSY_REG   = 1'b1,
   localparam int OB_CW = $clog2(OBUF_DEPTH + 1),
   localparam int TQ_CW = $clog2(TQ_DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             glob_rst,
   input logic             trig,
   input logic             rd_req,
   input logic [31:0]      rd_data,
   input logic             busy,
   input logic [OB_CW-1:0] ob_lvl,
   input logic             ob_empty,
   input logic [TQ_CW-1:0] tq_lvl,
   input logic             tq_full,
   input logic [47:0]      time_val,
   input logic             wr_en,
   input logic [31:0]      wr_data
);
   if (BUSY_REG) begin : g_busy_chk
      // R8
      busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ob_lvl >= OB_CW'(BUSY_LVL)) |=> busy);
      // R8
      busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ob_lvl < OB_CW'(BUSY_LVL)) |=> !busy);
   end

   // R11
   time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      glob_rst |=> (time_val == 48'd0));
   // R11
   time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_rst |=> (time_val == $past(time_val) + 48'd1));
   // R1
   nodata_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && ob_empty) |=> (rd_data == 32'hF000_0000));
   // R4
   cont_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[31]) |-> (wr_data[30:24] == 7'd0));
   // R9
   trig_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && tq_full) |=> (tq_lvl <= $past(tq_lvl)));
   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ob_lvl <= OB_CW'(OBUF_DEPTH));
endmodule

bind evblk_fmt evblk_fmt_chk #(
   .OBUF_DEPTH(OBUF_DEPTH), .BUSY_LVL(BUSY_LVL), .TQ_DEPTH(TQ_DEPTH), .BUSY_REG(BUSY_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .glob_rst(glob_rst), .trig(trig), .rd_req(rd_req),
   .rd_data(rd_data), .busy(busy), .ob_lvl(ob_lvl), .ob_empty(ob_empty),
   .tq_lvl(tq_lvl), .tq_full(tq_full), .time_val(time_val),
   .wr_en(ow_valid && ow_ready), .wr_data(ow_data)
);

// File: tb/evblk_fmt_test.sv
module evblk_fmt_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        glob_rst = 1'b1;
   logic        trig = 1'b0;
   logic [4:0]  slot_id = 5'd19;
   logic [10:0] evt_per_blk = 11'd1;
   logic        pad4 = 1'b0;
   logic        rd_req = 1'b0;
   logic [31:0] rd_data;
   logic        busy;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   longint edge_cnt = 0;
   longint g_edge = 0;
   int tnum = 0;
   int bnum = 0;
   logic [47:0] tstamp_q[$];
   logic [31:0] exp_q[$];
   string       tag_q[$];

   evblk_fmt #(.OBUF_DEPTH(16), .BUSY_LVL(12), .TQ_DEPTH(4), .BUSY_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .glob_rst(glob_rst), .trig(trig), .slot_id(slot_id),
      .evt_per_blk(evt_per_blk), .pad4(pad4), .rd_req(rd_req), .rd_data(rd_data), .busy(busy)
   );

   always #2 clk = ~clk;
   always @(posedge clk) edge_cnt <= edge_cnt + 1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic release_glob();
      @(negedge clk);
      glob_rst = 1'b0;
      g_edge = edge_cnt;
   endtask

   // hold trig high for n cycles; the first acc of them are expected to be accepted
   task automatic fire(input int n, input int acc);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         trig = 1'b1;
         if (i < acc) tstamp_q.push_back(48'(edge_cnt - g_edge));
      end
      @(negedge clk);
      trig = 1'b0;
   endtask

   task automatic build_block(input int n, input bit p4);
      int wc, tot;
      exp_q.push_back({1'b1, 4'd0, slot_id, 11'(n), 11'(bnum)}); tag_q.push_back("R2");
      for (int i = 0; i < n; i++) begin
         logic [47:0] t;
         t = tstamp_q.pop_front();
         exp_q.push_back({1'b1, 4'd2, 27'(tnum)}); tag_q.push_back("R3");
         exp_q.push_back({1'b1, 4'd3, 3'b000, t[47:24]}); tag_q.push_back("R4");
         exp_q.push_back({8'h00, t[23:0]}); tag_q.push_back("R4");
         tnum++;
      end
      wc = 2 + 3 * n;
      exp_q.push_back({1'b1, 4'd1, slot_id, 22'(wc)}); tag_q.push_back("R5");
      tot = wc;
      while ((p4 ? (tot % 4) : (tot % 2)) != 0) begin
         exp_q.push_back(32'hF800_0000); tag_q.push_back("R6");
         tot++;
      end
      bnum++;
   endtask

   task automatic read_word(output logic [31:0] w);
      @(negedge clk);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      w = rd_data;
   endtask

   task automatic drain();
      logic [31:0] w;
      while (exp_q.size() > 0) begin
         string r;
         logic [31:0] e;
         e = exp_q.pop_front();
         r = tag_q.pop_front();
         read_word(w);
         check({r, " R12 word"}, w, e);
         idle(2);
      end
      read_word(w);
      check("R1 empty after block", w, 32'hF000_0000);
   endtask

   initial begin
      logic [31:0] w;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      check("R8 busy after reset", {31'd0, busy}, 32'd0);
      read_word(w);
      check("R1 read on empty", w, 32'hF000_0000);
      idle(3);
      release_glob();
      idle(5);

      // sweep event counts and both padding modes (R2..R7, R12)
      for (int p = 0; p < 2; p++) begin
         for (int n = 1; n <= 3; n++) begin
            @(negedge clk);
            evt_per_blk = 11'(n);
            pad4 = p[0];
            for (int e = 0; e < n; e++) begin
               fire(1, 1);
               idle(10);
            end
            idle(30);
            build_block(n, p[0]);
            drain();
         end
      end

      // R8, R9: fill the buffer, then overrun the pending queue
      @(negedge clk);
      evt_per_blk = 11'd9;
      pad4 = 1'b0;
      for (int e = 0; e < 3; e++) begin fire(1, 1); idle(10); end
      idle(5);
      check("R8 busy low at 10 words", {31'd0, busy}, 32'd0);
      fire(1, 1); idle(15);
      check("R8 busy high at 13 words", {31'd0, busy}, 32'd1);
      fire(1, 1); idle(20);
      check("R8 busy high when full", {31'd0, busy}, 32'd1);
      fire(6, 4);                       // R9: two of these are dropped
      idle(10);
      build_block(9, 1'b0);
      drain();
      check("R8 busy low after drain", {31'd0, busy}, 32'd0);

      // R10, R11: event count 0 means 1; time restarts after a new global reset
      @(negedge clk);
      glob_rst = 1'b1;
      evt_per_blk = 11'd0;
      idle(6);
      release_glob();
      idle(7);
      fire(1, 1);
      idle(30);
      build_block(1, 1'b0);
      drain();

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule